// File: doc/BRIEF.md
# Branch Target Buffer with Last-Outcome Direction Bit

This block sits in the fetch stage and is looked up with the current fetch address. It is a direct-mapped table. One lookup tells the fetch stage three things: whether the instruction at that address is a branch the table has already seen (a tag hit), where that branch went when it was last taken (the stored target), and which way it went the last time it executed (a single direction bit). From these the block forms the address to fetch next. That address is the stored target when the entry hits and its direction bit says taken. In every other case it is the fetch address plus 4.

Branch outcomes are known only at the final pipeline stage. A separate resolve port, driven from that stage, writes the real direction and target back into the table. The lookup is combinational on the table contents. A resolve changes the table at the next clock edge, so a lookup in the same cycle as a resolve sees the old contents.

Each entry is a small state machine with three states:
- `ST_EMPTY`: no branch recorded.
- `ST_NT`: valid, last outcome not taken.
- `ST_TK`: valid, last outcome taken.

An entry moves between these states through four transitions:
- ALLOCATE: `ST_EMPTY` moves to `ST_TK` on a taken resolve. It moves to `ST_NT` on a not-taken resolve, but only when `ALLOC_NT` is 1.
- FLIP: a resolve that matches the stored tag sets the state to the resolved direction.
- REPLACE: a resolve with a different tag at a valid index overwrites the entry, under the same rule as ALLOCATE.
- HOLD: anything else leaves the entry unchanged.

There is no hysteresis. A single differing outcome changes the prediction.

Top module: `btb_last_dir`

## Requirements
- R1: After reset every entry is `ST_EMPTY`. Every lookup then gives `pred_hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R2: A taken resolve for an absent branch allocates its entry. From the next cycle, a lookup of that address gives `pred_hit`=1, `pred_taken`=1, `pred_target` equal to the resolved target, and `next_pc`=`pred_target`.
- R3: On a hit whose direction bit is not-taken, the outputs are `pred_hit`=1 and `pred_taken`=0, with `next_pc`=`fetch_pc`+4. `pred_target` still shows the stored target.
- R4: The direction bit follows the last resolved outcome of a matching branch. One not-taken resolve turns a taken prediction into not-taken, and one taken resolve turns it back.
- R5: The index is `fetch_pc[7:2]` and every other PC bit is compared as the tag. An address with the same index but any different tag bit, including bit 31, misses.
- R6: With `ALLOC_NT`=0 (the default), a not-taken resolve for a branch not in the table writes nothing. That branch still misses afterwards, and the entry already at that index is left intact.
- R7: A taken resolve at an index held by a different tag replaces the entry. The old address then misses and the new one hits.
- R8: A lookup in the same cycle as a resolve to the same index returns the contents from before that resolve.
- R9: `pred_taken` is never 1 while `pred_hit` is 0.
- R10: A resolve that hits overwrites the stored target with the resolved target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Fetch address being looked up |
| pred_hit | output | 1 | Entry valid and tag matches |
| pred_taken | output | 1 | Hit and direction bit is taken |
| pred_target | output | 32 | Stored target of the indexed entry |
| next_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A branch resolved this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction, 1 means taken |
| res_target | input | 32 | Resolved taken target |

## Verification
The lookup outputs are combinational, so each lookup result is due in the same cycle its `fetch_pc` is applied. A resolve is first visible to a lookup in the cycle after the clock edge that captures it. The driver applies one lookup and at most one resolve shortly after each falling edge and queues the result expected for that same cycle. The monitor compares that result before the next rising edge, so a resolve's effect is always checked one queued step later than the resolve itself, and the same-cycle read-before-write case falls out of the same timing.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_NT    = 2'd1,
        ST_TK    = 2'd2
    } ent_state_t;
endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int IDX_W    = 6,
    parameter int TAG_W    = 26,
    parameter bit ALLOC_NT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output ent_state_t        rd_state,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [PC_W-1:0]   rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_taken,
    input  logic [PC_W-1:0]   wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;

    ent_state_t            state_q [ENTRIES];
    logic [TAG_W-1:0]      tag_q   [ENTRIES];
    logic [PC_W-1:0]       tgt_q   [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        ent_state_t state_d;
        logic       load;

        always_comb begin
            state_d = state_q[e];
            load    = 1'b0;
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                unique case (state_q[e])
                    ST_EMPTY: begin
                        if (wr_taken || ALLOC_NT) begin
                            state_d = wr_taken ? ST_TK : ST_NT;
                            load    = 1'b1;
                        end
                    end
                    ST_NT, ST_TK: begin
                        if (tag_q[e] == wr_tag) begin
                            state_d = wr_taken ? ST_TK : ST_NT;
                            load    = 1'b1;
                        end else if (wr_taken || ALLOC_NT) begin
                            state_d = wr_taken ? ST_TK : ST_NT;
                            load    = 1'b1;
                        end
                    end
                    default: state_d = ST_EMPTY;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) state_q[e] <= ST_EMPTY;
            else        state_q[e] <= state_d;
        end

        always_ff @(posedge clk) begin
            if (load) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_tgt;
            end
        end
    end

    always_comb begin
        rd_state = state_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26,
    parameter int INC   = 4
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TAG_W-1:0] pc_tag,
    input  ent_state_t       ent_state,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_tgt,
    output logic             hit,
    output logic             taken,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  npc
);
    always_comb begin
        hit    = (ent_state != ST_EMPTY) && (ent_tag == pc_tag);
        taken  = 1'b0;
        unique case (ent_state)
            ST_TK:           taken = hit;
            ST_NT, ST_EMPTY: taken = 1'b0;
            default:         taken = 1'b0;
        endcase
        target = ent_tgt;
        npc    = taken ? ent_tgt : pc + PC_W'(INC);
    end
endmodule

// File: rtl/btb_last_dir.sv
module btb_last_dir
    import btb_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int IDX_W    = 6,
    parameter int OFF_W    = 2,
    parameter bit ALLOC_NT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    output logic [PC_W-1:0] next_pc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target
);
    localparam int TAG_W = PC_W - IDX_W;
    localparam int HI    = OFF_W + IDX_W;
    localparam int INC   = 1 << OFF_W;

    logic [IDX_W-1:0] f_idx, r_idx;
    logic [TAG_W-1:0] f_tag, r_tag;
    ent_state_t       rd_state;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_tgt;

    assign f_idx = fetch_pc[HI-1:OFF_W];
    assign r_idx = res_pc[HI-1:OFF_W];
    assign f_tag = {fetch_pc[PC_W-1:HI], fetch_pc[OFF_W-1:0]};
    assign r_tag = {res_pc[PC_W-1:HI], res_pc[OFF_W-1:0]};

    btb_store #(
        .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ALLOC_NT(ALLOC_NT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_state(rd_state), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .wr_en(res_valid), .wr_idx(r_idx), .wr_tag(r_tag),
        .wr_taken(res_taken), .wr_tgt(res_target)
    );

    btb_lookup #(
        .PC_W(PC_W), .TAG_W(TAG_W), .INC(INC)
    ) u_lookup (
        .pc(fetch_pc), .pc_tag(f_tag),
        .ent_state(rd_state), .ent_tag(rd_tag), .ent_tgt(rd_tgt),
        .hit(pred_hit), .taken(pred_taken), .target(pred_target), .npc(next_pc)
    );
endmodule

// File: rtl/btb_last_dir_chk.sv
module btb_last_dir_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_target,
    input logic [PC_W-1:0] next_pc,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic [PC_W-1:0] res_target
);
    p_taken_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    p_not_taken_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> next_pc == fetch_pc + PC_W'(4));

    p_taken_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> next_pc == pred_target);

    p_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid && res_taken) && fetch_pc == $past(res_pc))
        |-> (pred_hit && pred_taken && pred_target == $past(res_target)));

    p_flip_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid && !res_taken) && fetch_pc == $past(res_pc))
        |-> !pred_taken);

    p_reset_empty_r1: assert property (@(posedge clk)
        !$past(rst_n) && rst_n |-> !pred_hit);
endmodule

bind btb_last_dir btb_last_dir_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_btb_last_dir.sv
module sim_btb_last_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_target, next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    always #10 clk = ~clk;

    btb_last_dir u0 (.*);

    typedef struct {
        string       req;
        logic [31:0] pc;
        logic        hit;
        logic        tk;
        logic [31:0] tgt;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic step(input string req, input logic [31:0] pc,
                        input logic e_hit, input logic e_tk, input logic [31:0] e_tgt,
                        input logic rv, input logic [31:0] rpc,
                        input logic rtk, input logic [31:0] rtgt);
        exp_t x;
        @(negedge clk);
        fetch_pc   = pc;
        res_valid  = rv;
        res_pc     = rpc;
        res_taken  = rtk;
        res_target = rtgt;
        x.req = req; x.pc = pc; x.hit = e_hit; x.tk = e_tk; x.tgt = e_tgt;
        q.push_back(x);
    endtask

    task automatic look(input string req, input logic [31:0] pc,
                        input logic e_hit, input logic e_tk, input logic [31:0] e_tgt);
        step(req, pc, e_hit, e_tk, e_tgt, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t x;
                logic [31:0] e_npc;
                x = q.pop_front();
                e_npc = (x.hit && x.tk) ? x.tgt : x.pc + 32'd4;
                chk(x.req, "hit", {31'd0, pred_hit}, {31'd0, x.hit});
                chk(x.req, "taken", {31'd0, pred_taken}, {31'd0, x.tk});
                if (x.hit) chk(x.req, "target", pred_target, x.tgt);
                chk(x.req, "next_pc", next_pc, e_npc);
            end
        end
    end

    localparam logic [31:0] A = 32'h0000_1010;
    localparam logic [31:0] B = 32'h0000_2010;
    localparam logic [31:0] C = 32'h0000_0040;
    localparam logic [31:0] D = 32'h8000_0040;

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look("R1", A, 1'b0, 1'b0, '0);
        look("R1", C, 1'b0, 1'b0, '0);
        step("R8", A, 1'b0, 1'b0, '0, 1'b1, A, 1'b1, 32'h2000);
        step("R8", A, 1'b1, 1'b1, 32'h2000, 1'b1, A, 1'b0, 32'h2000);
        step("R3", A, 1'b1, 1'b0, 32'h2000, 1'b1, A, 1'b1, 32'h3000);
        look("R10", A, 1'b1, 1'b1, 32'h3000);
        step("R5", B, 1'b0, 1'b0, '0, 1'b1, B, 1'b0, 32'h5000);
        look("R6", B, 1'b0, 1'b0, '0);
        look("R6", A, 1'b1, 1'b1, 32'h3000);
        step("R4", A, 1'b1, 1'b1, 32'h3000, 1'b1, B, 1'b1, 32'h4000);
        look("R7", A, 1'b0, 1'b0, '0);
        look("R7", B, 1'b1, 1'b1, 32'h4000);
        step("R2", C, 1'b0, 1'b0, '0, 1'b1, C, 1'b1, 32'h0000_0100);
        look("R2", C, 1'b1, 1'b1, 32'h0000_0100);
        look("R5", D, 1'b0, 1'b0, '0);
        step("R9", C, 1'b1, 1'b1, 32'h100, 1'b1, C, 1'b0, 32'h100);
        step("R4", C, 1'b1, 1'b0, 32'h100, 1'b1, C, 1'b1, 32'h100);
        look("R4", C, 1'b1, 1'b1, 32'h100);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin : finisher
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule